// File: doc/BRIEF.md
# Configurable SPI Master Byte Engine

This block is the bit-level engine of an SPI master. A single start strobe, with a transmit byte, begins one 8-bit exchange. The engine pulls its active-low slave select low and produces the serial clock from a programmable half-period divider. It shifts the transmit byte out on the master-out line and collects the master-in line into a receive byte. When the exchange is over, it raises a one-cycle done pulse with the received byte.

Three run-time controls shape each exchange. The idle level of the serial clock selects its polarity. The clock phase selects whether data is captured on the leading edge or on the trailing edge of each clock period. The bit order selects whether the exchange starts with the most or the least significant bit. These controls and the divider value are captured when the start strobe is accepted, so software may change them while a transfer runs without disturbing it.

Top module: `spi_xfer_engine`

## Requirements
- R1: While idle, ss_n_o is 1, busy_o and done_o are 0, and sck_o equals cpol_i.
- R2: The mode is {cpol,cpha}. With cpha=0, data is sampled on each leading SCK edge (the edge leaving the idle level) and set up on each trailing edge. With cpha=1, data is set up on each leading edge and sampled on each trailing edge. mosi_o changes only on setup edges, or when the transfer starts.
- R3: With lsb_first_i=0, bit 7 travels first and bit 0 travels last. With lsb_first_i=1, bit 0 travels first and bit 7 travels last. The same order places the received bits in rx_byte_o.
- R4: With cpha=0, the first data bit is on mosi_o from the cycle in which ss_n_o goes low, before any SCK edge.
- R5: Each transfer makes exactly 16 SCK edges while ss_n_o is 0. SCK is back at its idle level before ss_n_o returns to 1.
- R6: An SCK half-period lasts max(half_div_i,1) system clocks. done_o rises 17*max(half_div_i,1) clocks after the clock edge that accepts start_i.
- R7: A start_i pulse that arrives while busy_o is 1 is ignored. It does not change the byte sent, the byte received or the timing of the transfer in progress.
- R8: done_o is high for exactly one cycle. In that cycle busy_o falls and rx_byte_o holds the received byte.
- R9: cpol_i, cpha_i, lsb_first_i and half_div_i are captured at start. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one byte exchange |
| tx_byte_i | input | 8 | Byte to send |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lsb_first_i | input | 1 | 0: MSB first, 1: LSB first |
| half_div_i | input | DIV_W | SCK half-period in system clocks (0 acts as 1) |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_n_o | output | 1 | Active-low slave select |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_byte_o | output | 8 | Received byte, valid with done_o |

## Verification
busy_o and ss_n_o change one clock after start_i is accepted. The first SCK edge follows max(half_div_i,1) clocks later, and done_o arrives exactly 17 half-periods after the accepting edge. The bench drives start_i on a falling clock edge and counts rising edges from the accepting one. It samples on falling edges, so the done cycle is compared against 17*max(half_div,1) exactly. A behavioural slave in the bench reacts to each SCK transition, using the mode it was told. It counts edges, captures mosi_o and drives miso_i half a period ahead of each sample edge. This checks data and order without looking inside the engine.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } xfer_state_t;

  localparam int unsigned EDGES_PER_BIT = 2;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] last_cnt;

  // zero is treated as one clock per half-period
  always_comb begin
    last_cnt = (half_div_i == '0) ? '0 : half_div_i - 1'b1;
    tick_o   = run_i && (cnt_q == last_cnt);
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              lsb_first_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i)       tx_d = tx_i;
    else if (shift_i) tx_d = lsb_first_i ? (tx_q >> 1) : (tx_q << 1);

    rx_d = rx_q;
    if (load_i)        rx_d = '0;
    else if (sample_i) rx_d = lsb_first_i ? {miso_i, rx_q[DATA_W-1:1]}
                                          : {rx_q[DATA_W-2:0], miso_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi_o = lsb_first_i ? tx_q[0] : tx_q[DATA_W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              ss_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int unsigned EDGES  = EDGES_PER_BIT * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);

  xfer_state_t       state_q, state_d;
  logic              sck_q, sck_d;
  logic              ss_n_q, ss_n_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              cpol_q, cpha_q, lsb_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              cfg_en;

  logic              tick;
  logic              accept;
  logic              leading, sample_edge;
  logic              do_shift, do_sample;
  logic [DATA_W-1:0] shreg_rx;

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (state_q != ST_IDLE),
    .half_div_i (div_q),
    .tick_o     (tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .tx_i        (tx_byte_i),
    .lsb_first_i (lsb_q),
    .shift_i     (do_shift),
    .sample_i    (do_sample),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_o        (shreg_rx)
  );

  // edge roles: even index = leading edge, odd index = trailing edge
  always_comb begin
    accept      = (state_q == ST_IDLE) && start_i;
    cfg_en      = accept;
    leading     = ~edge_q[0];
    sample_edge = cpha_q ? ~leading : leading;
    do_sample   = (state_q == ST_RUN) && tick && sample_edge;
    // the first bit is already presented when select falls
    do_shift    = (state_q == ST_RUN) && tick && !sample_edge && (edge_q != '0);
  end

  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    ss_n_d  = ss_n_q;
    edge_d  = edge_q;
    rx_d    = rx_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          sck_d   = cpol_i;
          ss_n_d  = 1'b0;
          edge_d  = '0;
        end
      end
      ST_RUN: begin
        if (tick) begin
          sck_d  = ~sck_q;
          edge_d = edge_q + 1'b1;
          if (edge_q == EDGE_W'(EDGES - 1)) state_d = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (tick) begin
          state_d = ST_IDLE;
          ss_n_d  = 1'b1;
          done_d  = 1'b1;
          rx_d    = shreg_rx;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      ss_n_q  <= 1'b1;
      done_q  <= 1'b0;
      edge_q  <= '0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      ss_n_q  <= ss_n_d;
      done_q  <= done_d;
      edge_q  <= edge_d;
      rx_q    <= rx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      lsb_q  <= 1'b0;
      div_q  <= '0;
    end else if (cfg_en) begin
      cpol_q <= cpol_i;
      cpha_q <= cpha_i;
      lsb_q  <= lsb_first_i;
      div_q  <= half_div_i;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign sck_o     = busy_o ? sck_q : cpol_i;
  assign ss_n_o    = ss_n_q;
  assign done_o    = done_q;
  assign rx_byte_o = rx_q;
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic cpol_i,
  input logic sck_o,
  input logic mosi_o,
  input logic ss_n_o,
  input logic busy_o,
  input logic done_o
);
  // R1
  idle_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> ss_n_o);

  // R1
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sck_o == cpol_i));

  // R5
  busy_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ss_n_o);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $stable(sck_o)) |-> $stable(mosi_o));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o));

  // R7
  busy_start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !$fell(ss_n_o));
endmodule

bind spi_xfer_engine spi_xfer_engine_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .cpol_i  (cpol_i),
  .sck_o   (sck_o),
  .mosi_o  (mosi_o),
  .ss_n_o  (ss_n_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n;
  logic       start_i;
  logic [7:0] tx_byte_i;
  logic       cpol_i, cpha_i, lsb_first_i;
  logic [7:0] half_div_i;
  logic       miso_i;
  logic       sck_o, mosi_o, ss_n_o, busy_o, done_o;
  logic [7:0] rx_byte_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  // behavioural slave state
  logic       m_cpol, m_cpha, m_lsb;
  logic [7:0] s_tx, s_rx;
  int         s_edges, s_idx, s_rcnt;

  spi_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_byte_i(tx_byte_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .lsb_first_i(lsb_first_i),
    .half_div_i(half_div_i), .miso_i(miso_i), .sck_o(sck_o),
    .mosi_o(mosi_o), .ss_n_o(ss_n_o), .busy_o(busy_o), .done_o(done_o),
    .rx_byte_o(rx_byte_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge ss_n_o) begin
    s_edges = 0;
    s_idx   = 0;
    s_rcnt  = 0;
    s_rx    = 8'h00;
    miso_i  = m_lsb ? s_tx[0] : s_tx[7];
  end

  always @(sck_o) begin
    if (ss_n_o == 1'b0) begin
      if (((sck_o != m_cpol) ? 1'b1 : 1'b0) ^ m_cpha) begin
        if (s_rcnt < 8) begin
          if (m_lsb) s_rx[s_rcnt] = mosi_o;
          else       s_rx[7 - s_rcnt] = mosi_o;
        end
        s_rcnt = s_rcnt + 1;
      end else begin
        if (!(m_cpha && s_edges == 0) && s_idx < 7) s_idx = s_idx + 1;
        miso_i = m_lsb ? s_tx[s_idx] : s_tx[7 - s_idx];
      end
      s_edges = s_edges + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_div(input logic [7:0] hd);
    return (hd == 8'd0) ? 1 : int'(hd);
  endfunction

  // starts a transfer; returns after the accepting posedge, at the next negedge
  task automatic launch(input logic pol, input logic pha, input logic lsb,
                        input logic [7:0] hd, input logic [7:0] tx, input logic [7:0] stx);
    m_cpol = pol; m_cpha = pha; m_lsb = lsb; s_tx = stx;
    @(negedge clk);
    cpol_i = pol; cpha_i = pha; lsb_first_i = lsb; half_div_i = hd;
    tx_byte_i = tx; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_and_check(input string tag, input logic [7:0] hd,
                                  input logic [7:0] tx, input logic [7:0] stx, input int k0);
    int k = k0;
    while (!done_o && k < 20000) begin
      @(negedge clk);
      k++;
    end
    // R6: done exactly 17 half-periods after acceptance
    check(k == 17 * eff_div(hd), {tag, " R6 done timing"}, k, 17 * eff_div(hd));
    // R8: busy low, received byte valid with done
    check(busy_o == 1'b0, {tag, " R8 busy with done"}, busy_o, 0);
    check(rx_byte_o == stx, {tag, " R3 R2 rx byte"}, rx_byte_o, stx);
    check(s_rx == tx, {tag, " R3 R2 slave got tx"}, s_rx, tx);
    // R5: 16 edges, clock idle, select released
    check(s_edges == 16, {tag, " R5 edge count"}, s_edges, 16);
    check(ss_n_o == 1'b1 && sck_o == m_cpol, {tag, " R5 idle after"},
          {ss_n_o, sck_o}, {1'b1, m_cpol});
    @(negedge clk);
    check(done_o == 1'b0, {tag, " R8 done one cycle"}, done_o, 0);
  endtask

  task automatic t_reset;
    check(ss_n_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R1 reset outputs",
          {ss_n_o, busy_o, done_o}, 3'b100);
    check(sck_o == cpol_i, "R1 sck idle cpol0", sck_o, cpol_i);
    cpol_i = 1'b1;
    @(negedge clk);
    check(sck_o == 1'b1, "R1 sck idle cpol1", sck_o, 1);
    cpol_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_xfer(input logic pol, input logic pha, input logic lsb,
                        input logic [7:0] hd, input logic [7:0] tx, input logic [7:0] stx);
    string tag;
    logic  first;
    tag = $sformatf("m%0d%0d l%0d d%0d", pol, pha, lsb, hd);
    launch(pol, pha, lsb, hd, tx, stx);
    first = lsb ? tx[0] : tx[7];
    if (!pha) begin
      // R4: first bit present as select falls, before any SCK edge
      check(ss_n_o == 1'b0 && sck_o == pol && mosi_o == first, {tag, " R4 first bit"},
            {ss_n_o, sck_o, mosi_o}, {1'b0, pol, first});
    end
    finish_and_check(tag, hd, tx, stx, 0);
  endtask

  task automatic t_busy_start;
    int dones = 0;
    launch(1'b0, 1'b0, 1'b0, 8'd2, 8'hA5, 8'h3C);
    repeat (5) @(negedge clk);
    tx_byte_i = 8'h0F; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_and_check("R7 busy start", 8'd2, 8'hA5, 8'h3C, 6);
    for (int i = 0; i < 60; i++) begin
      if (done_o) dones++;
      @(negedge clk);
    end
    check(dones == 0 && busy_o == 1'b0 && ss_n_o == 1'b1, "R7 no second transfer",
          dones, 0);
  endtask

  task automatic t_latch;
    launch(1'b0, 1'b1, 1'b0, 8'd3, 8'h96, 8'hE1);
    repeat (4) @(negedge clk);
    cpol_i = 1'b1; cpha_i = 1'b0; lsb_first_i = 1'b1; half_div_i = 8'd1;
    repeat (10) @(negedge clk);
    cpol_i = 1'b0;
    finish_and_check("R9 latched cfg", 8'd3, 8'h96, 8'hE1, 14);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; tx_byte_i = 8'h00;
    cpol_i = 1'b0; cpha_i = 1'b0; lsb_first_i = 1'b0; half_div_i = 8'd1;
    miso_i = 1'b0; m_cpol = 1'b0; m_cpha = 1'b0; m_lsb = 1'b0;
    s_tx = 8'h00; s_rx = 8'h00; s_edges = 0; s_idx = 0; s_rcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xfer(1'b0, 1'b0, 1'b0, 8'd1, 8'hB4, 8'h5D);
    t_xfer(1'b0, 1'b1, 1'b0, 8'd2, 8'h81, 8'h7E);
    t_xfer(1'b1, 1'b0, 1'b0, 8'd3, 8'h3A, 8'hC9);
    t_xfer(1'b1, 1'b1, 1'b0, 8'd1, 8'hF0, 8'h0F);
    t_xfer(1'b0, 1'b0, 1'b1, 8'd2, 8'hB4, 8'h5D);
    t_xfer(1'b0, 1'b1, 1'b1, 8'd1, 8'h01, 8'h80);
    t_xfer(1'b1, 1'b0, 1'b1, 8'd4, 8'hC3, 8'h26);
    t_xfer(1'b1, 1'b1, 1'b1, 8'd2, 8'h6B, 8'hD2);
    t_xfer(1'b0, 1'b0, 1'b0, 8'd0, 8'hFF, 8'h00);
    t_xfer(1'b1, 1'b1, 1'b0, 8'd7, 8'h00, 8'hFF);
    t_busy_start();
    t_latch();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule